// File: doc/BRIEF.md
# Display Frame Fetch Sequencer

This block sequences the memory reads for one display panel. Software supplies two frame buffers, each given by a start (top) and end (bottom) byte address, together with the panel size, a colour depth code, a palette-handling mode and an optional line window. When the panel is switched on, the sequencer first checks that every buffer in use lies inside a programmable legal address range. If a palette is expected, it then reads the palette from the head of buffer 0.

On each frame tick the sequencer works out where the pixel data begins, since a palette sits ahead of the pixels and its size depends on the depth. It then checks that the whole frame fits in the current buffer and issues one read request per displayed line. In dual-buffer mode it alternates between the two buffers. A frame that does not fit raises a sync error and switches the panel off. The memory bus and the pixel path sit outside this block. It only produces byte addresses and byte lengths, and it waits for a completion strobe on each one.

Top module: `fb_frame_sequencer`

## Requirements
- R1: After reset `active`, `cur_buf`, `buf_cmp`, `rd_req` and all four event pulses are 0.
- R2: On a switch-on, `top0` and `bot0` must lie in [`ok_lo`, `ok_hi`] inclusive. When `dual` is 1, `top1` and `bot1` must lie there too. If any of them does not, `addr_err` pulses for one cycle, `active` stays 0 and no read is issued.
- R3: A successful switch-on with `pmode` other than 2 issues exactly one read at `top0` with length 512, then pulses `pal_done`. With `pmode` = 2 there is no palette read and no `pal_done`.
- R4: While `pmode` = 1, frame ticks are ignored: no reads, no `frame_done`, and `buf_cmp` is unchanged.
- R5: Pixel data starts at offset 0 when `pmode` = 2. Otherwise it starts at 512 for depth codes 3 to 7 and at 32 for depth codes 1 and 2. The first line read is at top of the current buffer + offset + first_line × line_bytes.
- R6: The needed size is offset + width×height×bpp/8. If it exceeds (bottom − top) + 2 of the current buffer, `sync_err` pulses, `active` drops and no line is read. Equality passes.
- R7: Line length is width×bpp/8 bytes, where width = `width_m1`+1. bpp is 2, 4, 8 or 16 for depth codes 1, 2, 3 and 4–7. Ticks with depth code 0 are ignored.
- R8: At each accepted frame, `buf_cmp[cur_buf]` is set. Then `cur_buf` toggles when `dual` = 1 and stays 0 otherwise. A switch-on clears `buf_cmp` and `cur_buf`.
- R9: With `win_en` = 1 and `win_first` = 1, lines `win_line` up to height−1 are read. With `win_en` = 1 and `win_first` = 0, lines 0 up to `win_line`−1 are read. Otherwise lines 0 up to height−1 are read, where height = `height_m1`+1.
- R10: Only one read is outstanding at a time. `rd_req`, `rd_addr` and `rd_len` hold steady until `rd_done`, and requests occur only while `active`.
- R11: `frame_done` pulses once after the last line of a frame completes. It also pulses when the panel is switched off with `pmode` other than 1.
- R12: A switch-on happens only on a low-to-high change of `en` seen since the last attempt. After an error, `en` must drop and rise again before the panel restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Panel switch-on request (level) |
| frame_tick | input | 1 | Request one frame refresh |
| pmode | input | 2 | Palette mode: 1 no display, 2 no palette, else palette read |
| depth | input | 3 | Colour depth code |
| dual | input | 1 | Alternate between two buffers |
| width_m1 | input | DIM_W | Pixels per line minus one |
| height_m1 | input | DIM_W | Lines per frame minus one |
| win_en | input | 1 | Line window enable |
| win_first | input | 1 | Window line is first line (1) or line count (0) |
| win_line | input | DIM_W | Window line number |
| top0 | input | AW | Buffer 0 start address |
| bot0 | input | AW | Buffer 0 end address |
| top1 | input | AW | Buffer 1 start address |
| bot1 | input | AW | Buffer 1 end address |
| ok_lo | input | AW | Lowest legal buffer address |
| ok_hi | input | AW | Highest legal buffer address |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read byte address |
| rd_len | output | DIM_W+2 | Read byte length |
| rd_done | input | 1 | Read complete strobe |
| active | output | 1 | Panel running |
| cur_buf | output | 1 | Buffer index for the next frame |
| buf_cmp | output | 2 | Per-buffer frame-started flags |
| pal_done | output | 1 | Palette read finished pulse |
| frame_done | output | 1 | Frame finished pulse |
| sync_err | output | 1 | Frame too large pulse |
| addr_err | output | 1 | Illegal buffer address pulse |

## Verification
The bench builds the block with its defaults, AW = 32 and DIM_W = 10. It drives panels of only a few pixels and lines, so each frame takes a handful of requests and every line address can be predicted exactly. Buffer bounds are chosen so that the size check lands exactly on its limit and one line past it. A separate buffer 1 with an illegal start address shows that dual mode alone brings the second buffer into the range check.

// File: rtl/fb_frame_sequencer.sv
module fb_frame_sequencer #(
  parameter int AW    = 32,
  parameter int DIM_W = 10,
  localparam int LW   = DIM_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_tick,
  input  logic [1:0]       pmode,
  input  logic [2:0]       depth,
  input  logic             dual,
  input  logic [DIM_W-1:0] width_m1,
  input  logic [DIM_W-1:0] height_m1,
  input  logic             win_en,
  input  logic             win_first,
  input  logic [DIM_W-1:0] win_line,
  input  logic [AW-1:0]    top0,
  input  logic [AW-1:0]    bot0,
  input  logic [AW-1:0]    top1,
  input  logic [AW-1:0]    bot1,
  input  logic [AW-1:0]    ok_lo,
  input  logic [AW-1:0]    ok_hi,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic [LW-1:0]    rd_len,
  input  logic             rd_done,
  output logic             active,
  output logic             cur_buf,
  output logic [1:0]       buf_cmp,
  output logic             pal_done,
  output logic             frame_done,
  output logic             sync_err,
  output logic             addr_err
);
  localparam int WW = DIM_W + 1;
  localparam int PW = 2 * WW + 5;
  localparam int CW = AW + PW + 2;

  typedef enum logic [1:0] {S_IDLE, S_PAL, S_LINE} state_t;
  state_t state;

  logic          armed;
  logic [WW-1:0] line, lend;
  logic [AW-1:0] addr_r;
  logic [LW-1:0] len_r;

  logic [WW-1:0] wid, hgt, fl, ll;
  logic [4:0]    bpp;
  logic [LW-1:0] step;
  logic [PW-1:0] prod;
  logic [9:0]    off;
  logic [CW-1:0] need;
  logic signed [CW-1:0] lim;
  logic [AW-1:0] sel_top, sel_bot;
  logic          addr_ok;

  function automatic logic in_rng(input logic [AW-1:0] a, lo, hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign wid = WW'(width_m1) + WW'(1);
  assign hgt = WW'(height_m1) + WW'(1);

  always_comb
    case (depth)
      3'd1:    bpp = 5'd2;
      3'd2:    bpp = 5'd4;
      3'd3:    bpp = 5'd8;
      default: bpp = 5'd16;
    endcase

  assign step = LW'((PW'(wid) * PW'(bpp)) >> 3);
  assign prod = PW'(wid) * PW'(hgt) * PW'(bpp);
  assign off  = (pmode == 2'd2) ? 10'd0 : ((depth >= 3'd3) ? 10'd512 : 10'd32);
  assign sel_top = cur_buf ? top1 : top0;
  assign sel_bot = cur_buf ? bot1 : bot0;
  assign need = CW'(off) + CW'(prod >> 3);
  assign lim  = $signed(CW'(sel_bot) - CW'(sel_top) + CW'(2));
  assign addr_ok = in_rng(top0, ok_lo, ok_hi) && in_rng(bot0, ok_lo, ok_hi) &&
                   (!dual || (in_rng(top1, ok_lo, ok_hi) && in_rng(bot1, ok_lo, ok_hi)));
  assign fl = (win_en && win_first)  ? WW'(win_line) : '0;
  assign ll = (win_en && !win_first) ? WW'(win_line) : hgt;

  assign rd_req  = (state == S_PAL) || (state == S_LINE && line < lend);
  assign rd_addr = addr_r;
  assign rd_len  = len_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; armed <= 1'b0; active <= 1'b0; cur_buf <= 1'b0;
      buf_cmp <= '0; line <= '0; lend <= '0; addr_r <= '0; len_r <= '0;
      pal_done <= 1'b0; frame_done <= 1'b0; sync_err <= 1'b0; addr_err <= 1'b0;
    end else begin
      pal_done <= 1'b0; frame_done <= 1'b0; sync_err <= 1'b0; addr_err <= 1'b0;
      if (!en) armed <= 1'b1;
      case (state)
        S_IDLE: begin
          if (active && !en) begin
            active <= 1'b0;
            frame_done <= (pmode != 2'd1);
          end else if (!active && en && armed) begin
            armed <= 1'b0;
            if (!addr_ok) addr_err <= 1'b1;
            else begin
              active <= 1'b1; cur_buf <= 1'b0; buf_cmp <= '0;
              if (pmode != 2'd2) begin
                state <= S_PAL; addr_r <= top0; len_r <= LW'(512);
              end
            end
          end else if (active && frame_tick && pmode != 2'd1 && depth != 3'd0) begin
            if ($signed(need) > lim) begin
              sync_err <= 1'b1; active <= 1'b0;
            end else begin
              buf_cmp[cur_buf] <= 1'b1;
              if (dual) cur_buf <= ~cur_buf;
              addr_r <= sel_top + AW'(off) + AW'(fl) * AW'(step);
              len_r  <= step;
              line   <= fl;
              lend   <= ll;
              state  <= S_LINE;
            end
          end
        end
        S_PAL: if (rd_done) begin
          pal_done <= 1'b1; state <= S_IDLE;
        end
        S_LINE: begin
          if (line >= lend) begin
            frame_done <= 1'b1; state <= S_IDLE;
          end else if (rd_done) begin
            line <= line + WW'(1);
            addr_r <= addr_r + AW'(step);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_done |=> rd_req && $stable(rd_addr) && $stable(rd_len));
  a_r10_req_active: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> active);
  a_r6_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !active);
  a_r2_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !active && !rd_req);
  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pal_done, frame_done, sync_err, addr_err}));
  a_r8_single_buf: assert property (@(posedge clk) disable iff (!rst_n)
    !dual && !$past(dual) && $rose(buf_cmp[0]) |-> !cur_buf);
endmodule

// File: tb/tb_fb_frame_sequencer.sv
module tb_fb_frame_sequencer;
  localparam int AW = 32;
  localparam int DIM_W = 10;
  localparam int LW = DIM_W + 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, frame_tick = 1'b0;
  logic [1:0] pmode = 2'd0;
  logic [2:0] depth = 3'd3;
  logic dual = 1'b0, win_en = 1'b0, win_first = 1'b0;
  logic [DIM_W-1:0] width_m1 = 3, height_m1 = 2, win_line = 0;
  logic [AW-1:0] top0 = 32'h2000, bot0 = 32'h2FFF, top1 = 32'h4000, bot1 = 32'h4FFF;
  logic [AW-1:0] ok_lo = 32'h1000, ok_hi = 32'h8FFF;
  logic rd_req, rd_done = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] rd_len;
  logic active, cur_buf, pal_done, frame_done, sync_err, addr_err;
  logic [1:0] buf_cmp;

  fb_frame_sequencer #(.AW(AW), .DIM_W(DIM_W)) dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_req = 0, n_pal = 0, n_fd = 0, n_se = 0, n_ae = 0, wcnt = 0;
  longint a_log[64];
  longint l_log[64];

  always @(negedge clk) begin
    if (pal_done) n_pal++;
    if (frame_done) n_fd++;
    if (sync_err) n_se++;
    if (addr_err) n_ae++;
    if (rd_done) rd_done = 1'b0;
    else if (rd_req) begin
      if (wcnt == 1) begin
        rd_done = 1'b1;
        if (n_req < 64) begin a_log[n_req] = rd_addr; l_log[n_req] = rd_len; end
        n_req++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_req = 0; n_pal = 0; n_fd = 0; n_se = 0; n_ae = 0;
  endtask

  task automatic go_on();
    @(negedge clk); en = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic go_off();
    @(negedge clk); en = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 active", active, 0);
    chk("R1 buf_cmp", buf_cmp, 0);
    chk("R1 cur_buf", cur_buf, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 pulses", n_pal + n_fd + n_se + n_ae, 0);
  endtask

  task automatic t_addr();
    pmode = 2'd2; bot0 = 32'h9000; clr();
    go_on();
    chk("R2 addr_err", n_ae, 1);
    chk("R2 inactive", active, 0);
    chk("R2 no read", n_req, 0);
    bot0 = 32'h2FFF;
    repeat (10) @(negedge clk);
    chk("R12 no restart while high", active, 0);
    go_off(); go_on();
    chk("R12 restart after toggle", active, 1);
    go_off();
    top1 = 32'h0100; dual = 1'b0; clr();
    go_on();
    chk("R2 single ignores buf1", active, 1);
    go_off();
    dual = 1'b1; clr();
    go_on();
    chk("R2 dual checks buf1", n_ae, 1);
    chk("R2 dual inactive", active, 0);
    go_off();
    top1 = 32'h4000; dual = 1'b0;
  endtask

  task automatic t_pal();
    pmode = 2'd0; clr();
    go_on();
    chk("R3 one read", n_req, 1);
    chk("R3 addr", a_log[0], 32'h2000);
    chk("R3 len", l_log[0], 512);
    chk("R3 pal_done", n_pal, 1);
    go_off();
    pmode = 2'd2; clr();
    go_on();
    chk("R3 mode2 no read", n_req, 0);
    chk("R3 mode2 no pal_done", n_pal, 0);
  endtask

  task automatic t_frame();
    depth = 3'd3; width_m1 = 3; height_m1 = 2; clr();
    tick();
    chk("R9 line count", n_req, 3);
    chk("R5 line0 addr", a_log[0], 32'h2000);
    chk("R7 line1 addr", a_log[1], 32'h2004);
    chk("R7 line2 addr", a_log[2], 32'h2008);
    chk("R7 len", l_log[0], 4);
    chk("R11 frame_done", n_fd, 1);
    chk("R8 buf_cmp", buf_cmp, 1);
    chk("R8 single cur_buf", cur_buf, 0);
  endtask

  task automatic t_depth0();
    depth = 3'd0; clr();
    tick();
    chk("R7 depth0 no read", n_req, 0);
    chk("R7 depth0 no frame_done", n_fd, 0);
    depth = 3'd3;
  endtask

  task automatic t_offset();
    go_off();
    pmode = 2'd0; depth = 3'd1; width_m1 = 7; height_m1 = 0;
    go_on(); clr();
    tick();
    chk("R5 small depth offset", a_log[0], 32'h2000 + 32);
    chk("R7 2bpp len", l_log[0], 2);
    depth = 3'd4; clr();
    tick();
    chk("R5 large depth offset", a_log[0], 32'h2000 + 512);
    chk("R7 16bpp len", l_log[0], 16);
  endtask

  task automatic t_mode1();
    pmode = 2'd1; clr();
    tick();
    chk("R4 no read", n_req, 0);
    chk("R4 no frame_done", n_fd, 0);
    chk("R4 buf_cmp kept", buf_cmp, 1);
  endtask

  task automatic t_size();
    go_off();
    pmode = 2'd2; depth = 3'd3; width_m1 = 3; height_m1 = 3; bot0 = 32'h200E;
    go_on(); clr();
    tick();
    chk("R6 exact fit reads", n_req, 4);
    chk("R6 exact fit no err", n_se, 0);
    height_m1 = 4; clr();
    tick();
    chk("R6 sync_err", n_se, 1);
    chk("R6 disabled", active, 0);
    chk("R6 no read", n_req, 0);
    bot0 = 32'h2FFF;
  endtask

  task automatic t_dual();
    go_off();
    dual = 1'b1; height_m1 = 0;
    go_on(); clr();
    tick();
    chk("R8 first buf addr", a_log[0], 32'h2000);
    chk("R8 buf_cmp first", buf_cmp, 1);
    chk("R8 toggled", cur_buf, 1);
    clr();
    tick();
    chk("R8 second buf addr", a_log[0], 32'h4000);
    chk("R8 buf_cmp both", buf_cmp, 3);
    chk("R8 back to 0", cur_buf, 0);
    go_off(); go_on();
    chk("R8 cleared on switch-on", buf_cmp, 0);
    dual = 1'b0;
  endtask

  task automatic t_win();
    height_m1 = 3; win_en = 1'b1; win_first = 1'b1; win_line = 1; clr();
    tick();
    chk("R9 first-line count", n_req, 3);
    chk("R9 first-line addr", a_log[0], 32'h2004);
    win_first = 1'b0; win_line = 2; clr();
    tick();
    chk("R9 limit count", n_req, 2);
    chk("R9 limit last addr", a_log[1], 32'h2004);
    win_en = 1'b0;
  endtask

  task automatic t_off();
    clr();
    go_off();
    chk("R11 off frame_done", n_fd, 1);
    chk("R11 off inactive", active, 0);
    pmode = 2'd1;
    go_on(); clr();
    go_off();
    chk("R11 mode1 off silent", n_fd, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_pal();
    t_frame();
    t_depth0();
    t_offset();
    t_mode1();
    t_size();
    t_dual();
    t_win();
    t_off();
    finish_run();
  end
endmodule